// File: doc/BRIEF.md
# Character-Row Raster Timing Generator

This block paces a text-mode display in units of character clocks. Three nested counters run inside it. A position counter walks across one character row, including its horizontal retrace slots. A scan counter steps through the sweeps that make up one character row. A row counter steps through the character rows of a frame, including the vertical retrace rows. From these counters the block drives horizontal and vertical retrace flags and a 4-bit scan-line address for an external character generator.

The format values are sampled into shadow registers while the `run` input is low. When `run` rises, the counters start from zero using those values. A light pen input is synchronised to the character clock. Its rising edge takes a snapshot of the position and row counters, and a valid flag stays set until software acknowledges it.

Top module: `raster_timer`

## Requirements
- R1: While running, the position counter counts one step per clock over `fmtCharsDisp + fmtCharsRetrace` positions per row. `hRetrace` is high for the positions numbered `fmtCharsDisp` and above, so each row has exactly `fmtCharsRetrace` high cycles.
- R2: `scanLine` holds the current sweep within a character row. It increases by one at the end of every row of positions and returns to 0 after the value `fmtLastLine`.
- R3: The row counter advances when the last sweep of a character row ends. `vRetrace` is high while the row number is `fmtRowsDisp` or above.
- R4: A frame lasts `fmtRowsDisp + fmtRowsRetrace` character rows. After the last row, the row counter returns to 0 and the frame repeats.
- R5: After a clock edge at which `run` was low, `hRetrace`, `vRetrace` and `scanLine` are all 0, and the counters restart from zero when `run` next rises.
- R6: Format inputs are taken only at edges where `run` is low. Changing them while running has no effect on the timing until the block is stopped and restarted.
- R7: `penIn` passes through a two-flop synchroniser, and then its rising edge is detected. If `penIn` is first sampled high at edge k, then at edge k+2 `penChar` and `penRow` load the position and row counter values that held before edge k+2. A held-high `penIn` captures only once.
- R8: `penValid` goes high with each capture. It goes low at an edge where `penAck` is high and no capture happens. A capture wins over a simultaneous acknowledge.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to run; low holds counters at zero and loads format |
| fmtCharsDisp | input | CHAR_W | Displayed positions per row |
| fmtCharsRetrace | input | CHAR_W | Horizontal retrace positions per row |
| fmtLastLine | input | LINE_W | Number of the last sweep in a character row |
| fmtRowsDisp | input | ROW_W | Displayed character rows per frame |
| fmtRowsRetrace | input | ROW_W | Vertical retrace rows per frame |
| penIn | input | 1 | Asynchronous light pen strobe |
| penAck | input | 1 | Acknowledge: clears the capture flag |
| hRetrace | output | 1 | Horizontal retrace interval |
| vRetrace | output | 1 | Vertical retrace interval |
| scanLine | output | LINE_W | Sweep address for the character generator |
| penChar | output | CHAR_W+1 | Captured position counter |
| penRow | output | ROW_W+1 | Captured row counter |
| penValid | output | 1 | A capture is waiting to be acknowledged |

## Verification
The bench builds the block with CHAR_W=4 and ROW_W=3. At these widths the largest format values (15 positions of display plus 15 of retrace, 16 sweeps, 7 plus 7 rows) fit within a few thousand cycles per frame, so full frames and counter-width limits can be reached. A tiny format of one position, one sweep and one row each way exercises the case where every wrap happens back to back. Light pen strobes land in both display and retrace regions and coincide with acknowledges.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef struct packed {
    logic loadFmt;
    logic clrCnt;
    logic stepChar;
    logic stepLine;
    logic stepRow;
    logic penCap;
    logic penClr;
  } rasterCtl_t;
endpackage

// File: rtl/raster_ctl.sv
module raster_ctl
  import raster_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       penIn,
  input  logic       penAck,
  input  logic       charLast,
  input  logic       lineLast,
  output rasterCtl_t ctl,
  output logic       active
);
  localparam int PIPE = SYNC_STAGES + 1;

  logic [PIPE-1:0] penPipe;

  // Synchroniser stages followed by one edge-history flop
  generate
    for (genvar i = 0; i < PIPE; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) penPipe[i] <= 1'b0;
        else if (i == 0) penPipe[i] <= penIn;
        else penPipe[i] <= penPipe[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) active <= 1'b0;
    else active <= run;
  end

  always_comb begin
    ctl.loadFmt  = !run;
    ctl.clrCnt   = !run;
    ctl.stepChar = run;
    ctl.stepLine = run && charLast;
    ctl.stepRow  = run && charLast && lineLast;
    ctl.penCap   = penPipe[SYNC_STAGES-1] && !penPipe[SYNC_STAGES];
    ctl.penClr   = penAck;
  end
endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
#(
  parameter int CHAR_W = 7,
  parameter int ROW_W  = 6,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rasterCtl_t        ctl,
  input  logic              active,
  input  logic [CHAR_W-1:0] fmtCharsDisp,
  input  logic [CHAR_W-1:0] fmtCharsRetrace,
  input  logic [LINE_W-1:0] fmtLastLine,
  input  logic [ROW_W-1:0]  fmtRowsDisp,
  input  logic [ROW_W-1:0]  fmtRowsRetrace,
  output logic              charLast,
  output logic              lineLast,
  output logic              hRetrace,
  output logic              vRetrace,
  output logic [LINE_W-1:0] scanLine,
  output logic [CHAR_W:0]   penChar,
  output logic [ROW_W:0]    penRow,
  output logic              penValid
);
  localparam int CNT_CW = CHAR_W + 1;
  localparam int CNT_RW = ROW_W + 1;

  logic [CHAR_W-1:0] shDisp, shHRet;
  logic [LINE_W-1:0] shLast;
  logic [ROW_W-1:0]  shRows, shVRet;
  logic [CNT_CW-1:0] charCnt, totChars;
  logic [CNT_RW-1:0] rowCnt, totRows;
  logic [LINE_W-1:0] lineCnt;
  logic              rowLast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shDisp <= '0; shHRet <= '0; shLast <= '0; shRows <= '0; shVRet <= '0;
    end else if (ctl.loadFmt) begin
      shDisp <= fmtCharsDisp;
      shHRet <= fmtCharsRetrace;
      shLast <= fmtLastLine;
      shRows <= fmtRowsDisp;
      shVRet <= fmtRowsRetrace;
    end
  end

  assign totChars = {1'b0, shDisp} + {1'b0, shHRet};
  assign totRows  = {1'b0, shRows} + {1'b0, shVRet};
  assign charLast = (charCnt == totChars - CNT_CW'(1));
  assign lineLast = (lineCnt == shLast);
  assign rowLast  = (rowCnt == totRows - CNT_RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clrCnt) charCnt <= '0;
    else if (ctl.stepChar) charCnt <= charLast ? '0 : charCnt + CNT_CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clrCnt) lineCnt <= '0;
    else if (ctl.stepLine) lineCnt <= lineLast ? '0 : lineCnt + LINE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clrCnt) rowCnt <= '0;
    else if (ctl.stepRow) rowCnt <= rowLast ? '0 : rowCnt + CNT_RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      penChar <= '0; penRow <= '0; penValid <= 1'b0;
    end else if (ctl.penCap) begin
      penChar <= charCnt; penRow <= rowCnt; penValid <= 1'b1;
    end else if (ctl.penClr) begin
      penValid <= 1'b0;
    end
  end

  assign hRetrace = active && (charCnt >= {1'b0, shDisp});
  assign vRetrace = active && (rowCnt >= {1'b0, shRows});
  assign scanLine = lineCnt;
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int CHAR_W = 7,
  parameter int ROW_W  = 6,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CHAR_W-1:0] fmtCharsDisp,
  input  logic [CHAR_W-1:0] fmtCharsRetrace,
  input  logic [LINE_W-1:0] fmtLastLine,
  input  logic [ROW_W-1:0]  fmtRowsDisp,
  input  logic [ROW_W-1:0]  fmtRowsRetrace,
  input  logic              penIn,
  input  logic              penAck,
  output logic              hRetrace,
  output logic              vRetrace,
  output logic [LINE_W-1:0] scanLine,
  output logic [CHAR_W:0]   penChar,
  output logic [ROW_W:0]    penRow,
  output logic              penValid
);
  rasterCtl_t ctl;
  logic active, charLast, lineLast;

  raster_ctl #(.SYNC_STAGES(2)) u_ctl (
    .clk(clk), .rst_n(rst_n), .run(run), .penIn(penIn), .penAck(penAck),
    .charLast(charLast), .lineLast(lineLast), .ctl(ctl), .active(active)
  );

  raster_dp #(.CHAR_W(CHAR_W), .ROW_W(ROW_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .active(active),
    .fmtCharsDisp(fmtCharsDisp), .fmtCharsRetrace(fmtCharsRetrace),
    .fmtLastLine(fmtLastLine), .fmtRowsDisp(fmtRowsDisp),
    .fmtRowsRetrace(fmtRowsRetrace), .charLast(charLast), .lineLast(lineLast),
    .hRetrace(hRetrace), .vRetrace(vRetrace), .scanLine(scanLine),
    .penChar(penChar), .penRow(penRow), .penValid(penValid)
  );
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int CHAR_W = 7,
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              penAck,
  input logic              hRetrace,
  input logic              vRetrace,
  input logic [LINE_W-1:0] scanLine,
  input logic [CHAR_W:0]   penChar,
  input logic              penValid
);
  p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (!hRetrace && !vRetrace && scanLine == '0));

  p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scanLine) |-> (scanLine == '0 || scanLine == $past(scanLine) + LINE_W'(1)));

  p_hret_mid_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hRetrace) |-> $stable(scanLine));

  p_vret_row_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vRetrace) |-> scanLine == '0);

  p_clear_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(penValid) |-> $past(penAck));

  p_snap_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(penChar) |-> penValid);
endmodule

bind raster_timer raster_timer_chk #(.CHAR_W(CHAR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .penAck(penAck), .hRetrace(hRetrace),
  .vRetrace(vRetrace), .scanLine(scanLine), .penChar(penChar), .penValid(penValid)
);

// File: tb/raster_timer_bench.sv
module raster_timer_bench;
  localparam int CW = 4, RW = 3, LW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, run = 1'b0, penIn = 1'b0, penAck = 1'b0;
  logic [CW-1:0] fmtCharsDisp = '0, fmtCharsRetrace = '0;
  logic [LW-1:0] fmtLastLine = '0;
  logic [RW-1:0] fmtRowsDisp = '0, fmtRowsRetrace = '0;
  logic hRetrace, vRetrace, penValid;
  logic [LW-1:0] scanLine;
  logic [CW:0] penChar;
  logic [RW:0] penRow;

  raster_timer #(.CHAR_W(CW), .ROW_W(RW), .LINE_W(LW)) u_raster_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .fmtCharsDisp(fmtCharsDisp),
    .fmtCharsRetrace(fmtCharsRetrace), .fmtLastLine(fmtLastLine),
    .fmtRowsDisp(fmtRowsDisp), .fmtRowsRetrace(fmtRowsRetrace),
    .penIn(penIn), .penAck(penAck), .hRetrace(hRetrace), .vRetrace(vRetrace),
    .scanLine(scanLine), .penChar(penChar), .penRow(penRow), .penValid(penValid)
  );

  int compared = 0, mismatched = 0;
  bit cmpOn = 0, done = 0;

  // Behavioural reference model
  int mc = 0, ml = 0, mr = 0, mAct = 0;
  int shD = 0, shR = 0, shL = 0, shRD = 0, shRR = 0;
  int mPC = 0, mPR = 0, mValid = 0;
  int penHist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    int oc, or_, edgeSeen;
    oc = mc; or_ = mr;
    edgeSeen = (penHist[1] == 1 && penHist[2] == 0);
    if (!rst_n) begin
      mc = 0; ml = 0; mr = 0; mAct = 0; shD = 0; shR = 0; shL = 0; shRD = 0; shRR = 0;
      mPC = 0; mPR = 0; mValid = 0; penHist = '{0, 0, 0};
    end else begin
      mAct = run;
      if (!run) begin
        shD = fmtCharsDisp; shR = fmtCharsRetrace; shL = fmtLastLine;
        shRD = fmtRowsDisp; shRR = fmtRowsRetrace;
        mc = 0; ml = 0; mr = 0;
      end else begin
        mc = mc + 1;
        if (mc == shD + shR) begin
          mc = 0; ml = ml + 1;
          if (ml > shL) begin
            ml = 0; mr = mr + 1;
            if (mr == shRD + shRR) mr = 0;
          end
        end
      end
      if (edgeSeen) begin mPC = oc; mPR = or_; mValid = 1; end
      else if (penAck) mValid = 0;
      penHist.push_front(int'(penIn));
      void'(penHist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmpOn && !done) begin
    chk("R1 hRetrace", hRetrace, (mAct != 0 && mc >= shD) ? 1 : 0);
    chk("R2 scanLine", scanLine, ml);
    chk("R3 R4 vRetrace", vRetrace, (mAct != 0 && mr >= shRD) ? 1 : 0);
    chk("R8 penValid", penValid, mValid);
    chk("R7 penChar", penChar, mPC);
    chk("R7 penRow", penRow, mPR);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setFmt(int d, int r, int l, int rd, int rr);
    fmtCharsDisp = CW'(d); fmtCharsRetrace = CW'(r); fmtLastLine = LW'(l);
    fmtRowsDisp = RW'(rd); fmtRowsRetrace = RW'(rr);
  endtask

  task automatic pulsePen(int hold);
    penIn = 1'b1; cyc(hold); penIn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int hiCount;
    setFmt(6, 3, 2, 4, 2);
    cyc(3);
    // R9: reset state
    chk("R9 reset hRetrace", hRetrace, 0);
    chk("R9 reset penValid", penValid, 0);
    chk("R9 reset scanLine", scanLine, 0);
    rst_n = 1'b1; cmpOn = 1;
    cyc(3);
    run = 1'b1;
    cyc(170);                       // more than one frame of 162 cycles (R4)
    pulsePen(1); cyc(7);
    pulsePen(12); cyc(4);
    penAck = 1'b1; cyc(1); penAck = 1'b0;
    cyc(20);
    // capture coinciding with acknowledge
    penIn = 1'b1; cyc(2); penAck = 1'b1; cyc(1); penAck = 1'b0; penIn = 1'b0;
    cyc(30);
    // R6: change format while running, then count retrace cycles in one row
    @(negedge clk); while (scanLine == 0) @(negedge clk);
    while (scanLine != 0) @(negedge clk);
    setFmt(2, 7, 5, 1, 1);
    hiCount = 0;
    for (int i = 0; i < 9; i++) begin hiCount += int'(hRetrace); cyc(1); end
    chk("R6 retrace count after live change", hiCount, 3);
    cyc(200);
    // R5: stop and check quiet outputs
    run = 1'b0; cyc(2);
    chk("R5 stopped hRetrace", hRetrace, 0);
    chk("R5 stopped vRetrace", vRetrace, 0);
    chk("R5 stopped scanLine", scanLine, 0);
    // widest format for these widths
    setFmt(15, 15, 15, 7, 7); cyc(2);
    run = 1'b1;
    cyc(3000); pulsePen(3); cyc(6); penAck = 1'b1; cyc(1); penAck = 1'b0;
    cyc(4000);
    run = 1'b0; setFmt(1, 1, 0, 1, 1); cyc(2);
    run = 1'b1; cyc(40); pulsePen(2); cyc(10);
    run = 1'b0; cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule